// File: doc/BRIEF.md
# Four-Lane I2S Audio Serializer

This block takes eight 24-bit audio samples from a controller running on the system clock. It sends them out as four I2S serial data lanes that move in lockstep. Each lane carries one stereo pair. The controller presents one sample at a time with a single-cycle strobe. After the eighth sample is held, the block raises `busy`. It then waits for the start of a left channel on the external word clock and shifts both channels of every lane out, most significant bit first. `busy` drops after the right channel is complete, and the controller may then load the next frame.

The bit clock and word clock come from outside the block. Each one passes through a two-flop synchroniser into the system clock domain. The falling edges of the bit clock are found by edge detection in that domain. All shifting is paced by those falling edges, so each data bit is stable well before the receiver samples it on the rising edge. The word clock is low for the left channel and high for the right channel. The first bit after each word-clock change is the one-bit I2S delay slot. If a channel period is longer than the 25 bit clocks that a sample needs, the remaining bits are sent as zero.

A four-state machine sequences the block:
- FILL: samples are accepted. The eighth accepted strobe moves the machine to ARMED.
- ARMED: the machine waits for a change of the word clock to low. That change moves it to LEFT.
- LEFT: left samples are shifted out. A change of the word clock to high moves it to RIGHT.
- RIGHT: right samples are shifted out. The 24th right bit moves it back to FILL.

Top module: `i2s4_quad_tx`

## Requirements
- R1: Accepted samples are assigned to lanes in arrival order. Sample 2k+1 is the left sample of lane k and sample 2k+2 is its right sample (k = 0..3). Lane k drives bit k of `sdata`.
- R2: All four lanes shift together, one bit per bit-clock period, most significant bit first. Each channel sends its 24 sample bits on the 24 bit periods that follow the delay slot.
- R3: `busy` rises on the system clock edge that captures the eighth sample. It stays high while the frame is waiting and while it is being shifted.
- R4: A strobe that arrives while `busy` is high changes neither the held samples nor the load position. The next frame therefore loads and shifts correctly.
- R5: Shifting starts only at a word-clock change to low (left channel) that follows a complete load. Until then `sdata` is zero.
- R6: The bit period that follows each word-clock change carries a zero delay slot. The sample MSB follows one bit clock later.
- R7: In a channel period longer than 25 bit clocks, every bit after the sample LSB is zero until the next word-clock change.
- R8: `busy` falls right after the right-channel LSB is sent, and the machine returns to FILL. While no frame is being sent, `sdata` is zero.
- R9: Synchronous reset clears the load position, the shift registers, `busy` and `sdata`. This holds even in the middle of a frame.
- R10: `sdata` changes only after a bit-clock falling edge and holds steady through the high phase of the bit clock. The system clock must run at least eight times faster than the bit clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe | input | 1 | Accepts `sample_in` on this cycle while in FILL |
| sample_in | input | 24 | Audio sample field |
| bclk_in | input | 1 | External bit clock, asynchronous |
| ws_in | input | 1 | External word clock: low = left, high = right |
| busy | output | 1 | Frame held or being sent; strobes are ignored |
| sdata | output | 4 | Serial data, bit k = lane k |

## Verification
The assertions assume that the bit clock and word clock are clean and that the word clock changes only together with a bit-clock fall. They also assume that the system clock oversamples the bit clock by at least eight times, and that every channel period has at least 25 bit clocks. The bench drives the bit clock with exactly eight system cycles per period, and it moves the word clock only at the bit-clock falls it generates. It uses channel lengths of 25, 32 and 40 bits. Loads are started just after a bit-clock rise. This keeps the final strobe well away from the cycles in which the block reacts to a bit-clock fall, so the behavioural model and the design agree on which word-clock change starts each frame.

// File: rtl/i2s4_pkg.sv
package i2s4_pkg;

    // Sequencer states of the serializer
    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_ARMED = 2'd1,
        ST_LEFT  = 2'd2,
        ST_RIGHT = 2'd3
    } tx_state_t;

endpackage

// File: rtl/i2s4_clk_sync.sv
module i2s4_clk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bclk_in,
    input  logic ws_in,
    output logic bit_tick,
    output logic ws_now
);

    logic [STAGES-1:0] bclk_sr;
    logic [STAGES-1:0] ws_sr;
    logic              bclk_prev;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) begin
                        bclk_sr[0] <= 1'b0;
                        ws_sr[0]   <= 1'b0;
                    end else begin
                        bclk_sr[0] <= bclk_in;
                        ws_sr[0]   <= ws_in;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) begin
                        bclk_sr[s] <= 1'b0;
                        ws_sr[s]   <= 1'b0;
                    end else begin
                        bclk_sr[s] <= bclk_sr[s-1];
                        ws_sr[s]   <= ws_sr[s-1];
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_prev <= 1'b0;
        end else begin
            bclk_prev <= bclk_sr[STAGES-1];
        end
    end

    // One-cycle pulse on each synchronised falling edge of the bit clock
    assign bit_tick = bclk_prev & ~bclk_sr[STAGES-1];
    assign ws_now   = ws_sr[STAGES-1];

endmodule

// File: rtl/i2s4_sample_loader.sv
module i2s4_sample_loader #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fill_en,
    input  logic             strobe,
    output logic [LANES-1:0] hi_we,
    output logic [LANES-1:0] lo_we,
    output logic             load_last
);

    localparam int SLOTS = 2 * LANES;
    localparam int CNT_W = $clog2(SLOTS);

    logic [CNT_W-1:0] cnt_q;
    logic             accept;

    assign accept    = fill_en & strobe;
    assign load_last = accept & (cnt_q == CNT_W'(SLOTS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (accept) begin
            cnt_q <= load_last ? '0 : cnt_q + 1'b1;
        end
    end

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_dec
            assign hi_we[g] = accept & (cnt_q == CNT_W'(2 * g));
            assign lo_we[g] = accept & (cnt_q == CNT_W'(2 * g + 1));
        end
    endgenerate

    // R4
    ignore_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !fill_en |=> $stable(cnt_q));

    // R1
    one_slot_write_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({hi_we, lo_we}) <= 1);

endmodule

// File: rtl/i2s4_lane_shifter.sv
module i2s4_lane_shifter #(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] din,
    input  logic                ld_hi,
    input  logic                ld_lo,
    input  logic                bit_tick,
    input  logic                send,
    output logic                sdo
);

    localparam int FRAME_W = 2 * SAMPLE_W;

    logic [FRAME_W-1:0] frame_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
        end else if (ld_hi) begin
            frame_q[FRAME_W-1:SAMPLE_W] <= din;
        end else if (ld_lo) begin
            frame_q[SAMPLE_W-1:0] <= din;
        end else if (send) begin
            frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sdo <= 1'b0;
        end else if (bit_tick) begin
            sdo <= send ? frame_q[FRAME_W-1] : 1'b0;
        end
    end

    // R10
    sdo_tick_only_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(bit_tick) |-> $stable(sdo));

endmodule

// File: rtl/i2s4_quad_tx.sv
module i2s4_quad_tx
    import i2s4_pkg::*;
#(
    parameter int SAMPLE_W    = 24,
    parameter int LANES       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                strobe,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic                bclk_in,
    input  logic                ws_in,
    output logic                busy,
    output logic [LANES-1:0]    sdata
);

    localparam int BC_W = $clog2(SAMPLE_W + 1);

    tx_state_t        state_q, state_d;
    logic [BC_W-1:0]  bit_cnt_q;
    logic             cnt_clr, cnt_inc;
    logic             send;
    logic             bit_tick, ws_now, ws_prev_q, word_edge;
    logic             load_last;
    logic             fill_en;
    logic [LANES-1:0] hi_we, lo_we;
    logic             busy_q;

    i2s4_clk_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst      (rst),
        .bclk_in  (bclk_in),
        .ws_in    (ws_in),
        .bit_tick (bit_tick),
        .ws_now   (ws_now)
    );

    assign fill_en = (state_q == ST_FILL);

    i2s4_sample_loader #(.LANES(LANES)) load_i (
        .clk       (clk),
        .rst       (rst),
        .fill_en   (fill_en),
        .strobe    (strobe),
        .hi_we     (hi_we),
        .lo_we     (lo_we),
        .load_last (load_last)
    );

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            i2s4_lane_shifter #(.SAMPLE_W(SAMPLE_W)) lane_i (
                .clk      (clk),
                .rst      (rst),
                .din      (sample_in),
                .ld_hi    (hi_we[l]),
                .ld_lo    (lo_we[l]),
                .bit_tick (bit_tick),
                .send     (send),
                .sdo      (sdata[l])
            );
        end
    endgenerate

    // Word-clock level as seen at the previous bit-clock fall
    always_ff @(posedge clk) begin
        if (rst) begin
            ws_prev_q <= 1'b0;
        end else if (bit_tick) begin
            ws_prev_q <= ws_now;
        end
    end

    assign word_edge = bit_tick & (ws_now != ws_prev_q);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FILL;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and shift control
    always_comb begin
        state_d = state_q;
        send    = 1'b0;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        unique case (state_q)
            ST_FILL: begin
                if (load_last) begin
                    state_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (word_edge && !ws_now) begin
                    state_d = ST_LEFT;
                    cnt_clr = 1'b1;
                end
            end
            ST_LEFT: begin
                if (word_edge) begin
                    state_d = ST_RIGHT;
                    cnt_clr = 1'b1;
                end else if (bit_tick && (bit_cnt_q < BC_W'(SAMPLE_W))) begin
                    send    = 1'b1;
                    cnt_inc = 1'b1;
                end
            end
            ST_RIGHT: begin
                if (bit_tick && (bit_cnt_q < BC_W'(SAMPLE_W))) begin
                    send    = 1'b1;
                    cnt_inc = 1'b1;
                    if (bit_cnt_q == BC_W'(SAMPLE_W - 1)) begin
                        state_d = ST_FILL;
                    end
                end
            end
        endcase
    end

    // Bit counter within a channel
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt_q <= '0;
        end else if (cnt_clr) begin
            bit_cnt_q <= '0;
        end else if (cnt_inc) begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
        end else begin
            busy_q <= (state_d != ST_FILL);
        end
    end

    assign busy = busy_q;

    // R3
    busy_on_full_chk: assert property (@(posedge clk) disable iff (rst)
        load_last |=> busy);

    // R8
    busy_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(state_q) == ST_RIGHT));

    // R5
    armed_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ARMED && bit_tick) |=> (sdata == '0));

    // R6
    delay_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LEFT && word_edge) |=> (sdata == '0));

    // R7
    pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LEFT && bit_tick && !word_edge
         && bit_cnt_q == BC_W'(SAMPLE_W)) |=> (sdata == '0));

endmodule

// File: tb/i2s4_quad_tx_tb_top.sv
module i2s4_quad_tx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int BCLK_HALF  = 4;
    localparam int SW         = 24;
    localparam int NL         = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          strobe = 1'b0;
    logic [SW-1:0] sample = '0;
    logic          bclk = 1'b1;
    logic          ws = 1'b0;
    logic          busy;
    logic [NL-1:0] sdata;

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2s4_quad_tx dut_i (
        .clk       (clk),
        .rst       (rst),
        .strobe    (strobe),
        .sample_in (sample),
        .bclk_in   (bclk),
        .ws_in     (ws),
        .busy      (busy),
        .sdata     (sdata)
    );

    int checks = 0;
    int bad = 0;
    int half_bits = 32;
    bit gen_on = 1'b0;

    // Behavioural reference: 0 idle, 1 waiting, 2 left, 3 right
    logic [SW-1:0] mfr [8];
    int            mstate = 0;
    int            mcnt = 0;
    bit            mbusy = 1'b0;
    logic          mws_old = 1'b0;
    logic [NL-1:0] exp_bit = '0;
    string         exp_tag = "R8";
    string         data_tag = "R1";
    event          ev_rise;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv, input string what);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, expv, $time);
        end
    endtask

    function automatic logic [SW-1:0] sample_of(input int f, input int i);
        if (f == 1) return (i % 2 == 1) ? 24'hFFFFFF : 24'h800001;
        return (24'h9C3A51 * (f * 8 + i + 1)) ^ {i[3:0], 20'h5A5A5};
    endfunction

    task automatic model_fall(input logic ws_new);
        bit edge_seen;
        if (rst) begin
            mws_old = 1'b0;
            exp_bit = '0;
            exp_tag = "R9";
            return;
        end
        edge_seen = (ws_new != mws_old);
        mws_old = ws_new;
        exp_bit = '0;
        case (mstate)
            1: begin
                exp_tag = "R5";
                if (edge_seen && !ws_new) begin
                    mstate = 2; mcnt = 0; exp_tag = "R6";
                end
            end
            2: begin
                if (edge_seen) begin
                    mstate = 3; mcnt = 0; exp_tag = "R6";
                end else if (mcnt < SW) begin
                    for (int l = 0; l < NL; l++) exp_bit[l] = mfr[2*l][SW-1-mcnt];
                    mcnt++;
                    exp_tag = data_tag;
                end else begin
                    exp_tag = "R7";
                end
            end
            3: begin
                if (mcnt < SW) begin
                    for (int l = 0; l < NL; l++) exp_bit[l] = mfr[2*l+1][SW-1-mcnt];
                    mcnt++;
                    exp_tag = "R2";
                    if (mcnt == SW) begin
                        mstate = 0; mbusy = 1'b0;
                    end
                end else begin
                    exp_tag = "R8";
                end
            end
            default: exp_tag = "R8";
        endcase
    endtask

    // Bit clock and word clock source with per-bit comparison
    initial begin : clock_source
        wait (gen_on);
        forever begin
            for (int ch = 0; ch < 2; ch++) begin
                int n;
                n = half_bits;
                for (int b = 0; b < n; b++) begin
                    @(negedge clk);
                    bclk = 1'b0;
                    if (b == 0) ws = ch[0];
                    model_fall(ws);
                    repeat (BCLK_HALF) @(negedge clk);
                    bclk = 1'b1;
                    if (!rst) begin
                        chk(sdata === exp_bit, exp_tag, 32'(sdata), 32'(exp_bit), "lane bits at rise");
                        chk(busy === mbusy, mbusy ? "R3" : "R8", 32'(busy), 32'(mbusy), "busy at rise");
                    end
                    -> ev_rise;
                    repeat (BCLK_HALF - 1) @(negedge clk);
                    if (!rst) chk(sdata === exp_bit, "R10", 32'(sdata), 32'(exp_bit), "lane bits held high phase");
                end
            end
        end
    end

    task automatic load_frame(input int f);
        wait (!mbusy);
        @(ev_rise);
        for (int i = 0; i < 8; i++) begin
            strobe = 1'b1;
            sample = sample_of(f, i);
            mfr[i] = sample_of(f, i);
            if (i == 7) begin
                mbusy = 1'b1;
                mstate = 1;
            end
            @(negedge clk);
        end
        strobe = 1'b0;
        sample = '0;
        chk(busy === 1'b1, "R3", 32'(busy), 32'd1, "busy after eighth strobe");
    endtask

    task automatic stray_strobes();
        @(ev_rise);
        for (int i = 0; i < 3; i++) begin
            strobe = 1'b1;
            sample = 24'h5EED00 + 24'(i);
            @(negedge clk);
        end
        strobe = 1'b0;
        sample = '0;
        chk(busy === 1'b1, "R4", 32'(busy), 32'd1, "busy kept through stray strobes");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL R8 watchdog act=timeout exp=done");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin : stimulus
        repeat (6) @(negedge clk);
        chk(sdata === '0, "R9", 32'(sdata), 32'd0, "lanes in reset");
        chk(busy === 1'b0, "R9", 32'(busy), 32'd0, "busy in reset");
        rst = 1'b0;
        gen_on = 1'b1;

        load_frame(0);
        data_tag = "R4";
        stray_strobes();
        load_frame(1);
        load_frame(2);
        data_tag = "R1";
        half_bits = 25;
        load_frame(3);
        load_frame(4);
        half_bits = 40;
        load_frame(5);

        // Reset in the middle of a left channel
        wait (mstate == 2 && mcnt > 4);
        @(ev_rise);
        rst = 1'b1;
        mstate = 0;
        mbusy = 1'b0;
        mws_old = 1'b0;
        repeat (3) @(negedge clk);
        chk(sdata === '0, "R9", 32'(sdata), 32'd0, "lanes after mid-frame reset");
        chk(busy === 1'b0, "R9", 32'(busy), 32'd0, "busy after mid-frame reset");
        @(ev_rise);
        @(ev_rise);
        rst = 1'b0;

        half_bits = 32;
        load_frame(6);
        wait (!mbusy);
        repeat (4) @(ev_rise);

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule